// File: doc/BRIEF.md
# Multi-Source Maskable Reset Controller

This block collects four kinds of reset request and turns them into one reset output per internal domain. The requests are a power-on reset, an external hard reset pin, a host-bus reset pin, and three soft-reset actions that software starts by writing to a control word. The domains are the host-bus interface, the general register file, the reset-mask register itself, the connection-valid flags, the interrupt pending/in-service registers, and a forwarded reset for a secondary port.

Each request reaches its own set of domains. A mask register that only power-on can reinitialise decides whether the hard pin, the bus pin (for the register side and for the forwarding path) and the soft resets have any effect. Pin resets assert at once, without a clock. They release only after a two-stage synchroniser. A soft reset is a pulse of fixed length, and its control bit clears itself when the pulse ends.

Software reaches the block through a 32-bit control word with byte enables and a combinational read-back. Byte 0 holds the soft-reset triggers. Byte 1 holds the mask bits. Byte 2 is reserved. Byte 3 holds a master output-enable byte, which is stored here as part of the register domain.

Top module: `reset_hub`

## Requirements
- R1: While rst_ni is low, bus_if_rst_o, regs_rst_o, sel_rst_o, cvf_rst_o and irq_rst_o are all 1 and fwd_rst_o is asserted. After reset, rd_data_o reads 0x00000F00: all mask bits are 1 and the enable byte is 0.
- R2: The mask bit for the hard pin is byte 1 bit 0. When it is 1, hard_rst_ni low asserts regs_rst_o, cvf_rst_o and irq_rst_o, and leaves sel_rst_o and bus_if_rst_o at 0. When it is 0, the pin has no effect on any output.
- R3: bus_rst_ni low always asserts bus_if_rst_o. If byte 1 bit 1 is 1, it also asserts regs_rst_o, cvf_rst_o and irq_rst_o.
- R4: If byte 1 bit 2 is 1, bus_rst_ni low asserts fwd_rst_o. The asserted level equals fwd_pol_i, so with fwd_pol_i=1 the output is active high and idles at 0. With the bit at 0, fwd_rst_o stays at its idle level.
- R5: The soft-reset triggers are in byte 0. Writing bit 0 asserts regs_rst_o, cvf_rst_o and irq_rst_o. Writing bit 1 asserts regs_rst_o and irq_rst_o only. Writing bit 2 asserts irq_rst_o only.
- R6: The soft-reset enable is byte 1 bit 3. While it is 0, writes to byte 0 are ignored: no output asserts and byte 0 reads back 0.
- R7: A soft reset drives its outputs for exactly 4 cycles, starting the cycle after the write edge. Its bit in byte 0 reads 1 during the pulse and 0 afterwards.
- R8: Pin-driven outputs assert asynchronously. They deassert on the second rising clock edge after the source goes inactive.
- R9: The mask register changes only on a write to byte 1 with wr_be_i[1]=1. Hard, bus and soft resets leave it unchanged, and bits 15:12 read 0.
- R10: Byte 3 is read/write. Every register-domain reset clears it: an enabled hard reset, a bus reset with byte 1 bit 1 set, and soft resets 1 and 2. Byte 2 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| hard_rst_ni | input | 1 | External hard reset pin, active low |
| bus_rst_ni | input | 1 | Host-bus reset pin, active low |
| fwd_pol_i | input | 1 | Asserted level of fwd_rst_o |
| wr_en_i | input | 1 | Control word write strobe |
| wr_be_i | input | 4 | Byte enables of the write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Control word read-back |
| bus_if_rst_o | output | 1 | Host-bus interface reset |
| regs_rst_o | output | 1 | General register file reset |
| sel_rst_o | output | 1 | Mask register reset |
| cvf_rst_o | output | 1 | Connection-valid flag reset |
| irq_rst_o | output | 1 | Interrupt pending/in-service reset |
| fwd_rst_o | output | 1 | Forwarded secondary-port reset |

## Verification
The assertions check on every cycle that the domains stay nested. A power-on reset covers every domain. A connection-flag reset always comes with a register reset, and a register reset always comes with an interrupt reset. They also check that the mask register holds its value unless byte 1 is written, that a synchroniser releases only after its source has gone inactive, that a soft pulse never ends early, and that a masked soft write starts nothing. Only the bench scenarios can show which domains each source reaches under each mask setting. They also show the exact four-cycle pulse window, the two-edge release latency, the forwarding polarity, and that the enable byte is cleared while the mask register survives.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;
  localparam int CTRL_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int N_SOFT  = 3;
  localparam int N_MASK  = 4;

  // byte lanes
  localparam int LANE_SOFT = 0;
  localparam int LANE_MASK = 1;
  localparam int LANE_MEN  = 3;

  // mask bits in byte 1
  localparam int MB_HARD = 0;
  localparam int MB_BUS  = 1;
  localparam int MB_FWD  = 2;
  localparam int MB_SOFT = 3;

  // soft trigger bits in byte 0
  localparam int SB_FULL = 0;
  localparam int SB_REGS = 1;
  localparam int SB_IRQ  = 2;

  // synchroniser cells
  localparam int SC_POR  = 0;
  localparam int SC_HARD = 1;
  localparam int SC_BIF  = 2;
  localparam int SC_BBE  = 3;
  localparam int SC_FWD  = 4;
  localparam int N_SYNC  = 5;

  typedef struct packed {
    logic bus_if;
    logic regs;
    logic sel;
    logic cvf;
    logic irq;
  } dom_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge arst_ni)
        if (!arst_ni) q <= '1;
        else          q <= '0;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge arst_ni)
        if (!arst_ni) q <= '1;
        else          q <= {q[STAGES-2:0], 1'b0};
    end
  endgenerate

  assign rst_o = q[STAGES-1];

  AST_REL_AFTER_SRC: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $fell(rst_o) |-> $past(arst_ni)); // R8
endmodule

// File: rtl/soft_pulse.sv
module soft_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic trig_i,
  input  logic en_i,
  output logic active_o
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (trig_i && en_i)   cnt_q <= CNT_W'(PULSE_LEN);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;

  assign active_o = (cnt_q != '0);

  // checker: length of the current high run
  logic [CNT_W-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                            run_q <= '0;
    else if (!active_o)                     run_q <= '0;
    else if (run_q != CNT_W'(PULSE_LEN))    run_q <= run_q + 1'b1;

  AST_PULSE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(active_o) && !$past(clr_i)) |-> (run_q == CNT_W'(PULSE_LEN))); // R7

  AST_MASKED_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !en_i && !active_o && !clr_i) |=> !active_o); // R6
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import rst_hub_pkg::*;
#(
  parameter int MASK_W = N_MASK
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              regs_clr_i,
  input  logic              wr_en_i,
  input  logic              wr_mask_be_i,
  input  logic              wr_men_be_i,
  input  logic [BYTE_W-1:0] wr_mask_i,
  input  logic [BYTE_W-1:0] wr_men_i,
  output logic [MASK_W-1:0] mask_o,
  output logic [BYTE_W-1:0] men_o
);
  logic [MASK_W-1:0] mask_q;
  logic [BYTE_W-1:0] men_q;

  // mask register: cleared by power-on only
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                      mask_q <= '1;
    else if (wr_en_i && wr_mask_be_i) mask_q <= wr_mask_i[MASK_W-1:0];

  // enable byte: member of the register domain
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                     men_q <= '0;
    else if (regs_clr_i)             men_q <= '0;
    else if (wr_en_i && wr_men_be_i) men_q <= wr_men_i;

  assign mask_o = mask_q;
  assign men_o  = men_q;

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_mask_be_i) |=> $stable(mask_q)); // R9

  AST_MEN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_clr_i |=> (men_q == '0)); // R10
endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import rst_hub_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_LEN   = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hard_rst_ni,
  input  logic        bus_rst_ni,
  input  logic        fwd_pol_i,
  input  logic        wr_en_i,
  input  logic [3:0]  wr_be_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        bus_if_rst_o,
  output logic        regs_rst_o,
  output logic        sel_rst_o,
  output logic        cvf_rst_o,
  output logic        irq_rst_o,
  output logic        fwd_rst_o
);
  localparam int LANE_LO_SOFT = LANE_SOFT * BYTE_W;
  localparam int LANE_LO_MASK = LANE_MASK * BYTE_W;
  localparam int LANE_LO_MEN  = LANE_MEN  * BYTE_W;

  logic [N_MASK-1:0] mask;
  logic [BYTE_W-1:0] men;
  logic [N_SYNC-1:0] sync_arst_n;
  logic [N_SYNC-1:0] sync_rst;
  logic [N_SOFT-1:0] soft_act;
  logic              ext_regs_rst;
  logic              soft_regs_rst;
  dom_t              dom;

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data_i[23:16], wr_data_i[LANE_LO_SOFT+BYTE_W-1:LANE_LO_SOFT+N_SOFT],
                            wr_be_i[2]};

  // async assert sources, gated by mask bits
  assign sync_arst_n[SC_POR]  = rst_ni;
  assign sync_arst_n[SC_HARD] = rst_ni & (hard_rst_ni | ~mask[MB_HARD]);
  assign sync_arst_n[SC_BIF]  = rst_ni & bus_rst_ni;
  assign sync_arst_n[SC_BBE]  = rst_ni & (bus_rst_ni | ~mask[MB_BUS]);
  assign sync_arst_n[SC_FWD]  = rst_ni & (bus_rst_ni | ~mask[MB_FWD]);

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .arst_ni (sync_arst_n[g]),
      .rst_o   (sync_rst[g])
    );
  end

  // pin-driven register resets also stop soft pulses
  assign ext_regs_rst = sync_rst[SC_HARD] | sync_rst[SC_BBE];

  for (genvar s = 0; s < N_SOFT; s++) begin : g_soft
    soft_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (ext_regs_rst),
      .trig_i   (wr_en_i & wr_be_i[LANE_SOFT] & wr_data_i[LANE_LO_SOFT + s]),
      .en_i     (mask[MB_SOFT]),
      .active_o (soft_act[s])
    );
  end

  assign soft_regs_rst = soft_act[SB_FULL] | soft_act[SB_REGS];

  ctrl_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .regs_clr_i   (ext_regs_rst | soft_regs_rst),
    .wr_en_i      (wr_en_i),
    .wr_mask_be_i (wr_be_i[LANE_MASK]),
    .wr_men_be_i  (wr_be_i[LANE_MEN]),
    .wr_mask_i    (wr_data_i[LANE_LO_MASK +: BYTE_W]),
    .wr_men_i     (wr_data_i[LANE_LO_MEN +: BYTE_W]),
    .mask_o       (mask),
    .men_o        (men)
  );

  // domain routing
  always_comb begin
    dom.sel    = sync_rst[SC_POR];
    dom.bus_if = sync_rst[SC_BIF];
    dom.cvf    = ext_regs_rst | soft_act[SB_FULL];
    dom.regs   = ext_regs_rst | soft_regs_rst;
    dom.irq    = dom.regs | soft_act[SB_IRQ];
  end

  assign bus_if_rst_o = dom.bus_if;
  assign regs_rst_o   = dom.regs;
  assign sel_rst_o    = dom.sel;
  assign cvf_rst_o    = dom.cvf;
  assign irq_rst_o    = dom.irq;
  assign fwd_rst_o    = fwd_pol_i ? sync_rst[SC_FWD] : ~sync_rst[SC_FWD];

  assign rd_data_o = {men, 8'h00, {(BYTE_W-N_MASK){1'b0}}, mask,
                      {(BYTE_W-N_SOFT){1'b0}}, soft_act};

  AST_POR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rst_o |-> (bus_if_rst_o && regs_rst_o && cvf_rst_o && irq_rst_o)); // R1
  AST_CVF_IN_REGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cvf_rst_o |-> regs_rst_o); // R5
  AST_REGS_IN_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_rst_o |-> irq_rst_o); // R2
endmodule

// File: tb/sim_reset_hub.sv
module sim_reset_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hard_n = 1'b1;
  logic        bus_n = 1'b1;
  logic        pol = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        o_bif, o_regs, o_sel, o_cvf, o_irq, o_fwd;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [3:0] mask_m = 4'hF;
  logic [7:0] men_m = 8'h00;

  always #5ns clk = ~clk;

  reset_hub u0 (
    .clk_i(clk), .rst_ni(rst_n), .hard_rst_ni(hard_n), .bus_rst_ni(bus_n),
    .fwd_pol_i(pol), .wr_en_i(wr_en), .wr_be_i(be), .wr_data_i(wdata),
    .rd_data_o(rdata), .bus_if_rst_o(o_bif), .regs_rst_o(o_regs),
    .sel_rst_o(o_sel), .cvf_rst_o(o_cvf), .irq_rst_o(o_irq), .fwd_rst_o(o_fwd)
  );

  // {bus_if, regs, sel, cvf, irq, fwd}
  function automatic logic [5:0] exp_dom(input logic por, input logic hard,
      input logic bif, input logic bbe, input logic bfwd, input logic [2:0] s,
      input logic p);
    logic regs, cvf, irq, fa;
    regs = por | hard | bbe | s[0] | s[1];
    cvf  = por | hard | bbe | s[0];
    irq  = regs | s[2];
    fa   = por | bfwd;
    return {por | bif, regs, por, cvf, irq, p ? fa : ~fa};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] men, input logic [3:0] m,
      input logic [2:0] s);
    return {men, 8'h00, 4'h0, m, 5'h00, s};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {o_bif, o_regs, o_sel, o_cvf, o_irq, o_fwd};
  endfunction

  // drive at negedge, write lands on the following posedge, returns at next negedge
  task automatic wr(input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; be = b; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; be = '0; wdata = '0;
    #1;
  endtask

  task automatic set_mask(input logic [3:0] m);
    wr(4'b0010, {16'h0, 4'hA, m, 8'h00});
    mask_m = m;
  endtask

  task automatic set_men(input logic [7:0] v);
    wr(4'b1000, {v, 8'h5A, 16'h0});
    men_m = v;
  endtask

  task automatic soft_case(input logic [2:0] b, input logic en);
    logic [2:0] s;
    s = en ? b : 3'b000;
    wr(4'b0001, {24'h0, 5'b11111, b});
    for (int i = 0; i < 4; i++) begin
      chk("R5 soft domains", {26'h0, outs()}, {26'h0, exp_dom(0, 0, 0, 0, 0, s, pol)});
      chk("R7 soft readback", {29'h0, rdata[2:0]}, {29'h0, s});
      if (i < 3) begin @(negedge clk); #1; end
    end
    if (s[0] | s[1]) men_m = 8'h00;
    @(negedge clk); #1;
    chk("R7 pulse end", {26'h0, outs()}, {26'h0, exp_dom(0, 0, 0, 0, 0, 3'b000, pol)});
    chk("R6 R10 readback after soft", rdata, exp_rd(men_m, mask_m, 3'b000));
  endtask

  task automatic hard_case(input int hold);
    logic e;
    e = mask_m[0];
    @(negedge clk);
    hard_n = 1'b0; #1;
    chk("R2 hard assert", {26'h0, outs()}, {26'h0, exp_dom(0, e, 0, 0, 0, 3'b000, pol)});
    repeat (hold) @(negedge clk);
    #1;
    chk("R2 hard held", {26'h0, outs()}, {26'h0, exp_dom(0, e, 0, 0, 0, 3'b000, pol)});
    hard_n = 1'b1;
    @(negedge clk); #1;
    chk("R8 hard release edge1", {26'h0, outs()}, {26'h0, exp_dom(0, e, 0, 0, 0, 3'b000, pol)});
    @(negedge clk); #1;
    chk("R8 hard release edge2", {26'h0, outs()}, {26'h0, exp_dom(0, 0, 0, 0, 0, 3'b000, pol)});
    if (e) men_m = 8'h00;
    chk("R9 R10 regs after hard", rdata, exp_rd(men_m, mask_m, 3'b000));
  endtask

  task automatic bus_case(input int hold);
    logic be_m, fw;
    be_m = mask_m[1];
    fw   = mask_m[2];
    @(negedge clk);
    bus_n = 1'b0; #1;
    chk("R3 R4 bus assert", {26'h0, outs()}, {26'h0, exp_dom(0, 0, 1, be_m, fw, 3'b000, pol)});
    repeat (hold) @(negedge clk);
    #1;
    chk("R3 R4 bus held", {26'h0, outs()}, {26'h0, exp_dom(0, 0, 1, be_m, fw, 3'b000, pol)});
    bus_n = 1'b1;
    @(negedge clk); #1;
    chk("R8 bus release edge1", {26'h0, outs()}, {26'h0, exp_dom(0, 0, 1, be_m, fw, 3'b000, pol)});
    @(negedge clk); #1;
    chk("R8 bus release edge2", {26'h0, outs()}, {26'h0, exp_dom(0, 0, 0, 0, 0, 3'b000, pol)});
    if (be_m) men_m = 8'h00;
    chk("R9 R10 regs after bus", rdata, exp_rd(men_m, mask_m, 3'b000));
  endtask

  initial begin
    #2ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    int kind;
    seed = $urandom(32'h1d5e);
    repeat (3) @(negedge clk);
    #1;
    chk("R1 por domains", {26'h0, outs()}, {26'h0, exp_dom(1, 0, 0, 0, 0, 3'b000, pol)});
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R8 por release edge1", {26'h0, outs()}, {26'h0, exp_dom(1, 0, 0, 0, 0, 3'b000, pol)});
    @(negedge clk); #1;
    chk("R1 por released", {26'h0, outs()}, {26'h0, exp_dom(0, 0, 0, 0, 0, 3'b000, pol)});
    chk("R1 reset readback", rdata, 32'h0000_0F00);

    set_men(8'hA5);
    chk("R10 enable byte write", rdata, exp_rd(men_m, mask_m, 3'b000));

    set_mask(4'hE);
    chk("R9 mask reserved bits", rdata, exp_rd(men_m, 4'hE, 3'b000));
    hard_case(2);

    set_mask(4'hF);
    hard_case(1);

    set_men(8'h3C);
    set_mask(4'h7);
    soft_case(3'b111, 1'b0);
    set_mask(4'hF);
    soft_case(3'b100, 1'b1);
    chk("R10 soft3 keeps enable byte", {24'h0, rdata[31:24]}, {24'h0, 8'h3C});

    pol = 1'b0;
    bus_case(1);
    pol = 1'b1;

    for (int it = 0; it < 60; it++) begin
      kind = $urandom % 3;
      set_mask(4'($urandom));
      set_men(8'($urandom));
      @(negedge clk);
      pol = 1'($urandom);
      case (kind)
        0: soft_case(3'($urandom), mask_m[3]);
        1: hard_case(1 + ($urandom % 3));
        default: bus_case(1 + ($urandom % 3));
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule